// File: doc/BRIEF.md
# 24-bit System Tick Timer

This block is a periodic down-counter that software programs through four 32-bit registers on a simple single-cycle register port. The registers are control/status, reload, current count and a read-only calibration word. Once enabled, the counter steps down by one on every step. A step is either a processor clock cycle or a synchronized rising edge of an external reference tick. When the count passes from 1 to 0, the block raises a sticky wrap flag. If the tick interrupt is enabled, it also sends a one-cycle interrupt request pulse to the interrupt controller. On the step after zero, the counter reloads. A reload value of N therefore gives a period of N+1 steps.

Firmware uses the block as an operating-system tick. It writes the current-count register to clear the counter, writes the reload value, and then enables the counter. The calibration word is fixed by parameters. It tells software the reload value for a 10 ms period, whether that value is exact, and whether a reference tick exists at all. When no reference tick exists, the clock-source bit stays at 1.

Top module: `systick_timer`

## Requirements
- R1: After reset, the control/status, reload and current-count registers read 0 and irq_req is low. The one exception is the clock-source bit, which reads 1 when NO_REF is set.
- R2: Registers are decoded at byte addresses 0x10 (control/status), 0x14 (reload), 0x18 (current count) and 0x1C (calibration). Read data appears on bus_rdata in the cycle after the request. Any other address reads 0, and a write to it changes no register.
- R3: The control/status layout is: bit 0 enable, bit 1 tick interrupt enable, bit 2 clock source (1 = processor clock, 0 = reference tick), bit 16 wrap flag. All other bits read 0.
- R4: The reload register keeps bits [23:0]. Bits [31:24] read 0.
- R5: With clock source 1 and reload N (1 to 0xFFFFFF), a wrap occurs every N+1 clock cycles.
- R6: A step taken while the count is 0 loads the reload value. With reload 0, the counter stays at 0 and never wraps.
- R7: A write of any data to the current-count register sets the count to 0 and clears the wrap flag.
- R8: The wrap flag sets on the 1-to-0 transition. A read of control/status returns it and then clears it.
- R9: On each wrap with tick interrupt enable at 1, irq_req is high for exactly one cycle, the cycle in which the count is 0. With tick interrupt enable at 0, irq_req stays low.
- R10: The calibration register reads {NO_REF, CAL_INEXACT, 6'b0, CAL_TENMS[23:0]}, and writes to it are ignored.
- R11: With NO_REF set, the clock-source bit reads 1 even after a write of 0.
- R12: With clock source 0, the counter steps once per rising edge of ref_tick, however long ref_tick stays high. It does not step while ref_tick is idle.
- R13: With enable at 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| ref_tick | input | 1 | Asynchronous external reference tick |
| irq_req | output | 1 | One-cycle interrupt request pulse on wrap |

## Verification
Each result has a fixed due cycle after its stimulus:
- A register read is due on bus_rdata at the falling edge after the clock edge that took the request.
- A register write takes effect at that same edge.
- irq_req is high in the cycle right after the clock edge where the count passes from 1 to 0.

The bench drives the bus on falling edges and samples one falling edge later. It measures wrap periods by counting falling edges between irq_req pulses, across a sweep of reload values, and compares each count with N+1. Reference-tick results pass through three register stages, so the bench holds each pulse and gap long enough that counts are compared only after the steps have settled.

// File: rtl/systick_pkg.sv
// Package: shared constants for the system tick timer.
// Holds the register offsets and control-bit positions that software decodes.
package systick_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CALIB  = 8'h1C;

    localparam int BIT_EN      = 0;
    localparam int BIT_TICKINT = 1;
    localparam int BIT_CLKSRC  = 2;
    localparam int BIT_FLAG    = 16;
    localparam int BIT_INEXACT = 30;
    localparam int BIT_NOREF   = 31;
endpackage

// File: rtl/systick_edge_sync.sv
// Module: systick_edge_sync
// Brings the asynchronous reference tick into the clock domain through a
// chain of SYNC_STAGES flops and emits a one-cycle pulse per rising edge.
// Assumes the tick stays high and low for at least two clock cycles each.
module systick_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            // Shift the input through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
            end
        end else begin : g_single
            // Single stage synchronizer variant.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end
    endgenerate

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[TOP];
    end

    assign rise_o = chain_q[TOP] & ~prev_q;
endmodule

// File: rtl/systick_counter.sv
// Module: systick_counter
// The down-counter with reload, the sticky wrap flag and the interrupt pulse.
// Assumes clr_i and flag_clr_i are single-cycle strobes from the register file.
// A clear has priority over a step in the same cycle.
module systick_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             clr_i,
    input  logic             flag_clr_i,
    input  logic             tickint_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] count_q;
    logic             flag_q;
    logic             irq_q;
    logic             wrap;

    // Detect the 1-to-0 transition that defines a wrap.
    always_comb begin
        wrap = step_i && !clr_i && (count_q == ONE);
    end

    // Count down, reload from zero, or clear on a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)          count_q <= ZERO;
        else if (clr_i)      count_q <= ZERO;
        else if (step_i) begin
            if (count_q == ZERO) count_q <= reload_i;
            else                 count_q <= count_q - ONE;
        end
    end

    // Sticky wrap flag: a wrap wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                   flag_q <= 1'b0;
        else if (wrap)                flag_q <= 1'b1;
        else if (clr_i || flag_clr_i) flag_q <= 1'b0;
    end

    // One-cycle interrupt request, aligned with the zero count.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= wrap && tickint_i;
    end

    assign count_o = count_q;
    assign flag_o  = flag_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/systick_regs.sv
// Module: systick_regs
// Register file: address decode, control bits, reload value, read mux and
// the clear strobes for the counter. Assumes single-cycle bus requests.
// Read data is registered, so it is valid one cycle after the request.
module systick_regs
    import systick_pkg::*;
#(
    parameter int               CNT_W       = 24,
    parameter logic [CNT_W-1:0] CAL_TENMS   = '0,
    parameter bit               CAL_INEXACT = 1'b0,
    parameter bit               NO_REF      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              flag_i,
    output logic              en_o,
    output logic              tickint_o,
    output logic              clksrc_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              count_clr_o,
    output logic              flag_clr_o
);
    localparam int PAD_W = DATA_W - CNT_W;

    logic              wr_ctrl, wr_reload, wr_count, rd_any, rd_ctrl;
    logic              en_q, tickint_q, clksrc_q;
    logic [CNT_W-1:0]  reload_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] calib_word;

    // Decode the access into per-register strobes.
    always_comb begin
        wr_ctrl   = sel_i && wr_i && (addr_i == OFS_CTRL);
        wr_reload = sel_i && wr_i && (addr_i == OFS_RELOAD);
        wr_count  = sel_i && wr_i && (addr_i == OFS_COUNT);
        rd_any    = sel_i && !wr_i;
        rd_ctrl   = rd_any && (addr_i == OFS_CTRL);
    end

    // Control bits; the clock source is pinned to 1 without a reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            tickint_q <= 1'b0;
            clksrc_q  <= NO_REF;
        end else if (wr_ctrl) begin
            en_q      <= wdata_i[BIT_EN];
            tickint_q <= wdata_i[BIT_TICKINT];
            clksrc_q  <= NO_REF ? 1'b1 : wdata_i[BIT_CLKSRC];
        end
    end

    // Reload value, truncated to the counter width.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];
    end

    // Fixed calibration word built from parameters.
    always_comb begin
        calib_word               = '0;
        calib_word[CNT_W-1:0]    = CAL_TENMS;
        calib_word[BIT_INEXACT]  = CAL_INEXACT;
        calib_word[BIT_NOREF]    = NO_REF;
    end

    // Select the word returned for the addressed register.
    always_comb begin
        rd_mux = '0;
        case (addr_i)
            OFS_CTRL: begin
                rd_mux[BIT_EN]      = en_q;
                rd_mux[BIT_TICKINT] = tickint_q;
                rd_mux[BIT_CLKSRC]  = clksrc_q;
                rd_mux[BIT_FLAG]    = flag_i;
            end
            OFS_RELOAD: rd_mux = {{PAD_W{1'b0}}, reload_q};
            OFS_COUNT:  rd_mux = {{PAD_W{1'b0}}, count_i};
            OFS_CALIB:  rd_mux = calib_word;
            default:    rd_mux = '0;
        endcase
    end

    // Register the read data for a one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_any) rdata_q <= rd_mux;
    end

    assign rdata_o     = rdata_q;
    assign en_o        = en_q;
    assign tickint_o   = tickint_q;
    assign clksrc_o    = clksrc_q;
    assign reload_o    = reload_q;
    assign count_clr_o = wr_count;
    assign flag_clr_o  = rd_ctrl;
endmodule

// File: rtl/systick_timer.sv
// Module: systick_timer (top)
// Periodic 24-bit down-counter timer with a register port, a selectable
// step source and an interrupt request pulse. Assumes ref_tick is slow
// compared with clk. All state uses a synchronous active-low reset.
module systick_timer
    import systick_pkg::*;
#(
    parameter int               CNT_W       = 24,
    parameter int               SYNC_STAGES = 2,
    parameter logic [CNT_W-1:0] CAL_TENMS   = '0,
    parameter bit               CAL_INEXACT = 1'b0,
    parameter bit               NO_REF      = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ref_tick,
    output logic        irq_req
);
    logic             ctl_en, ctl_tickint, ctl_clksrc;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cur_val;
    logic             cnt_flag;
    logic             cnt_clr, flag_clr;
    logic             ref_rise;
    logic             step;

    systick_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_tick),
        .rise_o   (ref_rise)
    );

    // Pick the step source: every clock or a reference tick edge.
    always_comb begin
        step = ctl_en && (ctl_clksrc || ref_rise);
    end

    systick_regs #(
        .CNT_W       (CNT_W),
        .CAL_TENMS   (CAL_TENMS),
        .CAL_INEXACT (CAL_INEXACT),
        .NO_REF      (NO_REF)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (bus_sel),
        .wr_i        (bus_wr),
        .addr_i      (bus_addr),
        .wdata_i     (bus_wdata),
        .rdata_o     (bus_rdata),
        .count_i     (cur_val),
        .flag_i      (cnt_flag),
        .en_o        (ctl_en),
        .tickint_o   (ctl_tickint),
        .clksrc_o    (ctl_clksrc),
        .reload_o    (reload_val),
        .count_clr_o (cnt_clr),
        .flag_clr_o  (flag_clr)
    );

    systick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .clr_i      (cnt_clr),
        .flag_clr_i (flag_clr),
        .tickint_i  (ctl_tickint),
        .reload_i   (reload_val),
        .count_o    (cur_val),
        .flag_o     (cnt_flag),
        .irq_o      (irq_req)
    );
endmodule

// File: rtl/systick_checker.sv
// Module: systick_checker
// Temporal checks on the timer, attached to every systick_timer by bind.
module systick_checker #(
    parameter int CNT_W  = 24,
    parameter bit NO_REF = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic             irq_req,
    input logic [CNT_W-1:0] cur_val,
    input logic             cnt_flag,
    input logic             ctl_en,
    input logic             ctl_tickint,
    input logic             ctl_clksrc
);
    logic count_wr;
    assign count_wr = bus_sel && bus_wr && (bus_addr == 8'h18);

    // R9: the request pulse lasts one cycle.
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

    // R9: the request only appears while the count is zero.
    a_r9_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (cur_val == '0));

    // R9: the request needs the tick interrupt enable.
    a_r9_irq_needs_tickint: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(ctl_tickint));

    // R7: a count write clears the count and the flag.
    a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        count_wr |=> (cur_val == '0) && !cnt_flag);

    // R8: the flag rises only together with a zero count.
    a_r8_flag_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnt_flag) |-> (cur_val == '0));

    // R13: a disabled counter holds its value.
    a_r13_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && !count_wr) |=> $stable(cur_val));

    generate
        if (NO_REF) begin : g_noref
            // R11: clock source stays at 1 without a reference.
            a_r11_clksrc_pinned: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> ctl_clksrc);
        end
    endgenerate
endmodule

bind systick_timer systick_checker #(.CNT_W(CNT_W), .NO_REF(NO_REF)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .irq_req     (irq_req),
    .cur_val     (cur_val),
    .cnt_flag    (cnt_flag),
    .ctl_en      (ctl_en),
    .ctl_tickint (ctl_tickint),
    .ctl_clksrc  (ctl_clksrc)
);

// File: tb/test_systick_timer.sv
// Bench: sweeps reload values and checks periods, flags, decode and the
// reference-tick path. A second instance covers the missing-reference case.
module test_systick_timer;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        ref_tick = 1'b0;
    logic        irq_a, irq_b;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    systick_timer #(.CAL_TENMS(24'd12345), .CAL_INEXACT(1'b1), .NO_REF(1'b0)) i_systick_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .ref_tick(ref_tick), .irq_req(irq_a));

    systick_timer #(.CAL_TENMS(24'd0), .CAL_INEXACT(1'b0), .NO_REF(1'b1)) i_systick_timer_noref (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .ref_tick(ref_tick), .irq_req(irq_b));

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] da, output logic [31:0] db);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        da = rdata_a; db = rdata_b;
        bus_sel = 1'b0;
    endtask

    task automatic wait_irq(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!irq_a && cyc < 2000);
    endtask

    task automatic ref_pulse(input int hi, input int lo);
        ref_tick = 1'b1;
        repeat (hi) @(negedge clk);
        ref_tick = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] ra, rb;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values.
        check({31'b0, irq_a}, 32'h0, "R1 irq");
        bus_read(8'h10, ra, rb);
        check(ra, 32'h0, "R1 ctrl");
        check(rb, 32'h4, "R1 ctrl noref");
        bus_read(8'h14, ra, rb); check(ra, 32'h0, "R1 reload");
        bus_read(8'h18, ra, rb); check(ra, 32'h0, "R1 count");

        // R10: calibration words, then a write to it is ignored.
        bus_read(8'h1C, ra, rb);
        check(ra, 32'h4000_3039, "R10 calib");
        check(rb, 32'h8000_0000, "R10 calib noref");
        bus_write(8'h1C, 32'h0);
        bus_read(8'h1C, ra, rb);
        check(ra, 32'h4000_3039, "R10 calib after write");

        // R11: clock source stays 1 without a reference.
        bus_write(8'h10, 32'h0);
        bus_read(8'h10, ra, rb);
        check(rb, 32'h4, "R11 clksrc pinned");

        // R4 and R2: reload masking, unmapped address.
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_read(8'h14, ra, rb); check(ra, 32'h00FF_FFFF, "R4 reload mask");
        bus_write(8'h20, 32'h1234_5678);
        bus_write(8'h15, 32'h0000_0001);
        bus_read(8'h20, ra, rb); check(ra, 32'h0, "R2 unmapped read");
        bus_read(8'h14, ra, rb); check(ra, 32'h00FF_FFFF, "R2 unmapped write ignored");

        // R3: control layout with all bits written.
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, ra, rb); check(ra, 32'h7, "R3 ctrl layout");
        bus_write(8'h10, 32'h0);

        // R5 / R9: period sweep, measured between interrupt pulses.
        for (int n = 1; n <= 13; n++) begin
            int rl;
            rl = (n == 13) ? 99 : n;
            bus_write(8'h18, 32'h0);
            bus_write(8'h14, rl);
            bus_write(8'h10, 32'h7);
            wait_irq(cyc);
            for (int k = 0; k < 2; k++) begin
                wait_irq(cyc);
                check(cyc, rl + 1, $sformatf("R5 period reload %0d", rl));
            end
            // R6 / R13: irq seen at zero; the disabling edge still steps to the reload value.
            bus_write(8'h10, 32'h0);
            bus_read(8'h18, ra, rb); check(ra, rl, "R6 reload after zero");
            repeat (10) @(negedge clk);
            bus_read(8'h18, ra, rb); check(ra, rl, "R13 hold when disabled");
        end

        // R8: flag read once then cleared.
        bus_read(8'h10, ra, rb); check(ra, 32'h0001_0000, "R8 flag set");
        bus_read(8'h10, ra, rb); check(ra, 32'h0, "R8 flag cleared by read");

        // R9: no interrupt without tick interrupt enable; flag still sets.
        bus_write(8'h18, 32'h0);
        bus_write(8'h14, 32'd4);
        bus_write(8'h10, 32'h5);
        cyc = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (irq_a) cyc++;
        end
        check(cyc, 0, "R9 no irq when tickint off");
        bus_write(8'h10, 32'h0);
        bus_read(8'h10, ra, rb); check(ra, 32'h0001_0000, "R8 flag without irq");

        // R7: count write with arbitrary data clears count and flag.
        bus_write(8'h14, 32'd20);
        bus_write(8'h10, 32'h5);
        repeat (30) @(negedge clk);
        bus_write(8'h10, 32'h0);
        bus_write(8'h18, 32'hDEAD_BEEF);
        bus_read(8'h18, ra, rb); check(ra, 32'h0, "R7 count cleared");
        bus_read(8'h10, ra, rb); check(ra, 32'h0, "R7 flag cleared");

        // R6: reload 0 never wraps.
        bus_write(8'h14, 32'h0);
        bus_write(8'h10, 32'h7);
        cyc = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (irq_a) cyc++;
        end
        bus_write(8'h10, 32'h0);
        check(cyc, 0, "R6 reload zero no irq");
        bus_read(8'h18, ra, rb); check(ra, 32'h0, "R6 reload zero count");
        bus_read(8'h10, ra, rb); check(ra, 32'h0, "R6 reload zero flag");

        // R12: reference tick stepping.
        bus_write(8'h18, 32'h0);
        bus_write(8'h14, 32'd50);
        bus_write(8'h10, 32'h1);
        repeat (20) @(negedge clk);
        bus_read(8'h18, ra, rb); check(ra, 32'h0, "R12 idle reference");
        for (int p = 0; p < 6; p++) ref_pulse(3, 3);
        repeat (2) @(negedge clk);
        bus_read(8'h18, ra, rb); check(ra, 32'd45, "R12 six edges");
        ref_pulse(12, 4);
        repeat (2) @(negedge clk);
        bus_read(8'h18, ra, rb); check(ra, 32'd44, "R12 long pulse steps once");
        repeat (20) @(negedge clk);
        bus_read(8'h18, ra, rb); check(ra, 32'd44, "R12 no step while idle");
        bus_write(8'h10, 32'h0);

        finish_run();
    end
endmodule